// File: doc/BRIEF.md
# SPI Serial SRAM Slave Controller

This block is the device side of a byte-wide static memory reached over a four-wire serial link. While chip select is low, the block shifts in an 8-bit command on the serial input. A read or write command is followed by a 16-bit address and then any number of data bytes. A mode-set command is followed by one configuration byte. Reads stream bytes out on the serial output. Writes collect complete bytes and pass them to a synchronous 64K x 8 array. The array sits outside the block, on a request/response port.

The serial pins are oversampled by the block's own clock `clk`, which must run well above the serial clock. The addressing mode decides how the internal pointer moves after each data byte. In single-byte mode it stops. In paged mode it wraps inside a 32-byte page. In streaming mode it runs through the whole array and rolls over at the top.

The array port is valid/ready. A request (`mem_req_valid` with address, write flag and write data) is held unchanged until a cycle in which `mem_req_ready` is high. A read returns its byte with `mem_rsp_valid` exactly one cycle after acceptance. Serial read streaming has no gaps, so the array may hold `ready` low for at most one cycle at a time. Each serial clock half-period must also last at least six `clk` cycles. Within those limits, the next byte is always fetched before it is needed.

Top module: `spisram_slave`

## Requirements
- R1: A command is taken only after a high-to-low change of `cs_n` seen since reset; if `cs_n` is already low when reset ends, the block ignores all serial traffic until `cs_n` has gone high and then low again.
- R2: Bits move most significant first and are sampled on rising `sck`. Command 0x03 followed by a 16-bit address starts a read. The addressed byte is driven on `so_d` with `so_oe` high, each bit changing after a falling `sck` edge and valid at the next rising edge. The first bit follows the falling edge after the last address bit. Further bytes follow with no idle bit.
- R3: Command 0x02 followed by a 16-bit address starts a write. Each complete received byte is written to the array at the pointer, and the pointer then advances.
- R4: Command 0x01 followed by one byte loads the addressing mode from that byte's bits 7:6: 00 single-byte, 10 paged, 01 streaming, and 11 behaves as single-byte. `so_oe` stays low throughout this command.
- R5: In single-byte mode, each read or write transfers exactly one data byte. Further write bits are discarded, and `so_oe` falls after the eighth data bit of a read.
- R6: In paged mode, the pointer increments within an aligned 32-byte page and wraps from offset 31 to offset 0 of the same page.
- R7: In streaming mode, the pointer increments across page boundaries and rolls over from 0xFFFF to 0x0000.
- R8: Any other command byte makes the block ignore the rest of the transaction. `so_oe` stays low and no array request is made until `cs_n` rises.
- R9: Raising `cs_n` at any bit aborts the transaction. A partly received write byte is dropped without an array access, `so_oe` falls, and the next transaction starts from a clean command.
- R10: An array request keeps its address, write flag and data unchanged while `mem_req_valid` is high and `mem_req_ready` is low. Reads are answered by `mem_rsp_valid` one cycle after acceptance.
- R11: After reset, `so_oe` and `mem_req_valid` are low and the addressing mode is single-byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out pad (low means high impedance) |
| mem_req_valid | output | 1 | Array request pending |
| mem_req_ready | input | 1 | Array accepts the request this cycle |
| mem_req_we | output | 1 | Request is a write (1) or read (0) |
| mem_req_addr | output | 16 | Array byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Read byte returned, one cycle after acceptance |
| mem_rsp_rdata | input | 8 | Returned read byte |

## Verification
Each addressing mode is tried with a write burst and a longer read-back. The start addresses are chosen to tell the modes apart. A page-interior start with a burst that crosses offset 31 shows whether the pointer wraps or runs on. A start near 0xFFFF separates a true rollover from a page wrap. A three-byte write in single-byte mode, read back later in streaming mode, shows whether the extra bytes were dropped. Bursts run both with a stalling array and with an always-ready array, so a fetch that arrives late or a request that changes while stalled shows up as wrong read data. Directed cases cover chip select already low at reset, an unknown command, and aborts in the middle of a write byte and a read byte.

// File: rtl/spisram_pkg.sv
`timescale 1ns/1ps
package spisram_pkg;

  typedef enum logic [1:0] {
    AM_BYTE = 2'b00,
    AM_SEQ  = 2'b01,
    AM_PAGE = 2'b10
  } addr_mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_ADDR,
    S_RDATA,
    S_WDATA,
    S_MODE,
    S_HALT
  } sp_state_t;

  localparam logic [7:0] OP_MODE_WR = 8'h01;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;

  // reserved code 11 falls back to single-byte
  function automatic addr_mode_t mode_decode(input logic [1:0] f);
    case (f)
      2'b01:   return AM_SEQ;
      2'b10:   return AM_PAGE;
      default: return AM_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/spisram_sync.sv
`timescale 1ns/1ps
module spisram_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spisram_addr_ptr.sv
`timescale 1ns/1ps
module spisram_addr_ptr
  import spisram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  addr_mode_t        mode,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_nxt
);

  logic [ADDR_W-1:0] page_nxt;
  logic [ADDR_W-1:0] flat_nxt;

  assign flat_nxt = ptr + ADDR_W'(1);

  generate
    if (PAGE_W > 0 && PAGE_W < ADDR_W) begin : g_paged
      always_comb page_nxt = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};

      // R6
      page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_PAGE) |=>
          (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])))
        else $error("page mode pointer left its page");
    end else begin : g_flat
      always_comb page_nxt = flat_nxt;
    end
  endgenerate

  always_comb ptr_nxt = (mode == AM_PAGE) ? page_nxt : flat_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr_nxt;
  end

  // R7
  seq_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && mode == AM_SEQ && ptr == '1) |=> (ptr == '0))
    else $error("streaming pointer did not roll over");

endmodule

// File: rtl/spisram_mem_port.sv
`timescale 1ns/1ps
module spisram_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss,
  input  logic              iss_we,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
    end else if (iss) begin
      mem_req_valid <= 1'b1;
      mem_req_we    <= iss_we;
      mem_req_addr  <= iss_addr;
      mem_req_wdata <= iss_data;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)))
    else $error("array request changed while stalled");

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss |-> !(mem_req_valid && !mem_req_ready))
    else $error("new array request while previous one stalled");

endmodule

// File: rtl/spisram_slave.sv
`timescale 1ns/1ps
module spisram_slave
  import spisram_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so_d,
  output logic              so_oe,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam int SH_W  = ADDR_W - 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);

  // pin oversampling
  logic [2:0] syn_q;
  logic       sck_s, cs_s, si_s;
  logic       sck_prev, cs_prev;
  logic       sck_rise, sck_fall, cs_fall;

  spisram_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, cs_n, si}),
    .q     (syn_q)
  );

  assign sck_s    = syn_q[2];
  assign cs_s     = syn_q[1];
  assign si_s     = syn_q[0];
  assign sck_rise = sck_s & ~sck_prev;
  assign sck_fall = ~sck_s & sck_prev;
  assign cs_fall  = cs_prev & ~cs_s;

  // transaction state
  sp_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   sh;
  logic              is_rd;
  logic [DATA_W-1:0] out_sh;
  logic              so_oe_q;
  addr_mode_t        mode_q;
  logic [DATA_W-1:0] rd_buf;
  logic              rdv;

  logic [ADDR_W-1:0] addr_in;
  logic [DATA_W-1:0] byte_in;
  assign addr_in = {sh, si_s};
  assign byte_in = {sh[DATA_W-2:0], si_s};

  // pointer and array request control
  logic              p_load, p_adv;
  logic [ADDR_W-1:0] ptr, ptr_nxt;
  logic              iss, iss_we;
  logic [ADDR_W-1:0] iss_addr;

  always_comb begin
    p_load   = 1'b0;
    p_adv    = 1'b0;
    iss      = 1'b0;
    iss_we   = 1'b0;
    iss_addr = ptr;
    if (!cs_s) begin
      if (sck_rise) begin
        if (st == S_ADDR && cnt == LAST_ADDR) begin
          p_load   = 1'b1;
          iss      = is_rd;
          iss_addr = addr_in;
        end else if (st == S_WDATA && cnt == LAST_BIT) begin
          iss    = 1'b1;
          iss_we = 1'b1;
          p_adv  = 1'b1;
        end
      end else if (sck_fall && st == S_RDATA && cnt == '0 && mode_q != AM_BYTE) begin
        p_adv    = 1'b1;
        iss      = 1'b1;
        iss_addr = ptr_nxt;
      end
    end
  end

  spisram_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (p_load),
    .load_val (addr_in),
    .adv      (p_adv),
    .mode     (mode_q),
    .ptr      (ptr),
    .ptr_nxt  (ptr_nxt)
  );

  spisram_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mport (
    .clk           (clk),
    .rst_n         (rst_n),
    .iss           (iss),
    .iss_we        (iss_we),
    .iss_addr      (iss_addr),
    .iss_data      (byte_in),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b0;
      st       <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      out_sh   <= '0;
      so_oe_q  <= 1'b0;
      mode_q   <= AM_BYTE;
      rd_buf   <= '0;
      rdv      <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
      if (mem_rsp_valid) begin
        rd_buf <= mem_rsp_rdata;
        rdv    <= 1'b1;
      end
      if (cs_s) begin
        st      <= S_IDLE;
        cnt     <= '0;
        so_oe_q <= 1'b0;
      end else if (st == S_IDLE) begin
        if (cs_fall) begin
          st  <= S_CMD;
          cnt <= '0;
        end
      end else if (sck_rise) begin
        sh <= {sh[SH_W-2:0], si_s};
        case (st)
          S_CMD: begin
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              case (byte_in)
                OP_READ:    begin st <= S_ADDR; is_rd <= 1'b1; end
                OP_WRITE:   begin st <= S_ADDR; is_rd <= 1'b0; end
                OP_MODE_WR: st <= S_MODE;
                default:    st <= S_HALT;
              endcase
            end else cnt <= cnt + CNT_W'(1);
          end
          S_ADDR: begin
            if (cnt == LAST_ADDR) begin
              cnt <= '0;
              st  <= is_rd ? S_RDATA : S_WDATA;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_WDATA: begin
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (mode_q == AM_BYTE) st <= S_HALT;
            end else cnt <= cnt + CNT_W'(1);
          end
          S_RDATA: begin
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              if (mode_q == AM_BYTE) begin
                st      <= S_HALT;
                so_oe_q <= 1'b0;
              end
            end else cnt <= cnt + CNT_W'(1);
          end
          S_MODE: begin
            if (cnt == LAST_BIT) begin
              mode_q <= mode_decode(byte_in[DATA_W-1 -: 2]);
              st     <= S_HALT;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: ;
        endcase
      end else if (sck_fall && st == S_RDATA) begin
        if (cnt == '0) begin
          out_sh  <= rd_buf;
          rdv     <= 1'b0;
          so_oe_q <= 1'b1;
        end else begin
          out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_d  = out_sh[DATA_W-1];
  assign so_oe = so_oe_q;

  // R9
  so_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe)
    else $error("serial output still driven with chip select high");

  // R4
  mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(st) == S_MODE))
    else $error("mode changed outside a mode-set command");

  // R2
  prefetch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && sck_fall && st == S_RDATA && cnt == '0) |-> rdv)
    else $error("read byte not fetched before it was due");

endmodule

// File: tb/sim_spisram_slave.sv
`timescale 1ns/1ps
module sim_spisram_slave;

  localparam int HALF = 6;
  localparam int NV   = 7;
  // {mode[1:0], addr[15:0], write bytes, read bytes, first data}
  localparam logic [41:0] VEC [NV] = '{
    {2'b01, 16'h1234, 8'd3, 8'd3, 8'hA0},
    {2'b10, 16'h045E, 8'd4, 8'd5, 8'h10},
    {2'b01, 16'hFFFE, 8'd3, 8'd4, 8'h70},
    {2'b00, 16'h2000, 8'd3, 8'd2, 8'hC5},
    {2'b10, 16'h7FFF, 8'd2, 8'd2, 8'h33},
    {2'b11, 16'h2100, 8'd2, 8'd2, 8'h5A},
    {2'b01, 16'h2000, 8'd0, 8'd3, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si;
  logic so_d, so_oe;
  logic mem_req_valid, mem_req_ready, mem_req_we;
  logic [15:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [7:0] mem_rsp_rdata = 8'h00;

  always #2 clk = ~clk;

  spisram_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so_d(so_d), .so_oe(so_oe),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0, hold_viol = 0;
  int cyc = 0;
  logic stall_en = 1'b0;
  logic done = 1'b0;

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] a, input logic [1:0] m);
    if (m == 2'b10) return {a[15:5], a[4:0] + 5'd1};
    return a + 16'd1;
  endfunction

  // array model and port monitor
  logic [7:0] arr  [int];
  logic [7:0] expm [int];
  logic       pw = 1'b0;
  logic [15:0] pa;
  logic [7:0]  pd;
  logic        pwe;

  assign mem_req_ready = !(stall_en && (cyc % 3 == 0));

  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (pw && !(mem_req_valid && mem_req_addr == pa && mem_req_wdata == pd && mem_req_we == pwe))
      hold_viol = hold_viol + 1;
    pw  = mem_req_valid && !mem_req_ready;
    pa  = mem_req_addr;
    pd  = mem_req_wdata;
    pwe = mem_req_we;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        arr[int'(mem_req_addr)] = mem_req_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rsp_rdata <= arr.exists(int'(mem_req_addr)) ? arr[int'(mem_req_addr)] : dflt(mem_req_addr);
        mem_rsp_valid <= 1'b1;
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  function automatic logic [7:0] exp_at(input logic [15:0] a);
    return expm.exists(int'(a)) ? expm[int'(a)] : dflt(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n,
                          output logic [7:0] rx, output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i]  = so_d;
      oe_all = oe_all & so_oe;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                          output logic oe_all, output logic oe_any);
    spi_bits(tx, 8, rx, oe_all, oe_any);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic head(input logic [7:0] op, input logic [15:0] a, output logic oe_any);
    logic [7:0] r; logic oa, o1, o2, o3;
    spi_byte(op, r, oa, o1);
    spi_byte(a[15:8], r, oa, o2);
    spi_byte(a[7:0], r, oa, o3);
    oe_any = o1 | o2 | o3;
  endtask

  task automatic set_mode(input logic [1:0] m);
    logic [7:0] r; logic oa, o1, o2;
    cs_lo();
    spi_byte(8'h01, r, oa, o1);
    spi_byte({m, 6'b101101}, r, oa, o2);
    cs_hi();
    chk(!(o1 | o2), "R4 SO idle during mode set", o1 | o2, 0);
  endtask

  initial begin
    logic [7:0] rx; logic oa, oy, oh;
    logic [15:0] a;
    int w0, r0;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0;
    repeat (5) @(negedge clk);
    chk(so_oe == 0 && mem_req_valid == 0, "R11 outputs in reset", {so_oe, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(so_oe == 0 && mem_req_valid == 0, "R11 outputs after reset", {so_oe, mem_req_valid}, 0);

    // R1: chip select already low at reset release, no edge
    w0 = wr_cnt; r0 = rd_cnt;
    head(8'h02, 16'h3000, oh);
    spi_byte(8'h55, rx, oa, oy);
    repeat (10) @(negedge clk);
    chk(wr_cnt == w0 && rd_cnt == r0, "R1 no command without select edge", wr_cnt - w0, 0);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);

    // R11: default single-byte mode read of untouched location
    cs_lo();
    head(8'h03, 16'h3000, oh);
    spi_byte(8'h00, rx, oa, oy);
    chk(rx == dflt(16'h3000) && oa, "R1/R11 first read after edge", rx, dflt(16'h3000));
    spi_byte(8'h00, rx, oa, oy);
    chk(!oy, "R11 default mode releases SO after one byte", oy, 0);
    cs_hi();

    // table of mode / burst vectors
    for (int vi = 0; vi < NV; vi++) begin
      logic [1:0] m; logic [7:0] wl, rl, sd; string tag; bit single;
      m  = VEC[vi][41:40];
      a  = VEC[vi][39:24];
      wl = VEC[vi][23:16];
      rl = VEC[vi][15:8];
      sd = VEC[vi][7:0];
      single = (m == 2'b00) || (m == 2'b11);
      tag = (m == 2'b01) ? "R7/R3/R2" : (m == 2'b10) ? "R6/R3/R2" :
            (m == 2'b00) ? "R5/R3" : "R4/R5";
      stall_en = vi[0];
      set_mode(m);
      if (wl != 0) begin
        logic [15:0] wa;
        wa = a;
        cs_lo();
        head(8'h02, a, oh);
        for (int i = 0; i < int'(wl); i++) begin
          spi_byte(sd + 8'(i), rx, oa, oy);
          if (!single || i == 0) expm[int'(wa)] = sd + 8'(i);
          wa = nxt(wa, m);
        end
        cs_hi();
        chk(!oh, {tag, " SO idle during write"}, oh, 0);
      end
      cs_lo();
      head(8'h03, a, oh);
      for (int i = 0; i < int'(rl); i++) begin
        spi_byte(8'h00, rx, oa, oy);
        if (single && i > 0)
          chk(!oy, {tag, " SO released after one byte"}, oy, 0);
        else
          chk(rx == exp_at(a) && oa, {tag, " read data"}, rx, exp_at(a));
        a = nxt(a, m);
      end
      cs_hi();
    end
    stall_en = 1'b0;
    chk(hold_viol == 0, "R10 request held while stalled", hold_viol, 0);

    // R8: unknown command
    w0 = wr_cnt; r0 = rd_cnt;
    cs_lo();
    head(8'h9F, 16'h1234, oh);
    spi_byte(8'hAA, rx, oa, oy);
    cs_hi();
    chk(!(oh | oy), "R8 SO idle after unknown command", oh | oy, 0);
    chk(wr_cnt == w0 && rd_cnt == r0, "R8 no array access", (wr_cnt - w0) + (rd_cnt - r0), 0);

    // R9: abort in the middle of a write byte
    set_mode(2'b01);
    w0 = wr_cnt;
    cs_lo();
    head(8'h02, 16'h3100, oh);
    spi_bits(8'hF0, 4, rx, oa, oy);
    cs_hi();
    chk(wr_cnt == w0, "R9 partial write byte dropped", wr_cnt - w0, 0);
    cs_lo();
    head(8'h03, 16'h3100, oh);
    spi_byte(8'h00, rx, oa, oy);
    chk(rx == dflt(16'h3100) && oa, "R9 location unchanged after abort", rx, dflt(16'h3100));
    // R9: abort in the middle of a read byte
    spi_bits(8'h00, 4, rx, oa, oy);
    cs_hi();
    chk(so_oe == 0, "R9 SO released on abort", so_oe, 0);
    cs_lo();
    head(8'h03, 16'h1234, oh);
    spi_byte(8'h00, rx, oa, oy);
    chk(rx == exp_at(16'h1234) && oa, "R9 clean restart after abort", rx, exp_at(16'h1234));
    cs_hi();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule